// File: doc/BRIEF.md
# Memory Region Guard with Console Port

The block sits between a 32-bit big-endian processor core and its memories. The core presents one access per cycle: an address, a kind (instruction fetch, load or store), byte-lane enables and write data. The guard decodes the address against a fixed, sparse map. It checks whether the kind of access is allowed in that region and steers the access to one of three places: a behavioural instruction RAM, a behavioural data RAM, or a one-character console. It returns read data in the same cycle for RAM regions.

A fetch from the word at address zero ends the program. The guard then raises a halt flag and keeps the low byte of the core's register 2 as the exit value. Any access that breaks the map rules raises a memory fault with code -11. A failed console write raises an I/O error with code -21. Halts and faults are sticky until reset. After that, every request is ignored. Console reads block until a byte arrives or the input stream ends, and the end of the stream reads back as -1. Console writes block until the output side is ready. A separate loading port fills the instruction RAM before the core starts.

Top module: `mem_guard`

## Requirements
- R1: A fetch (kind 0) whose address bits 31:2 are all zero and whose bits 1:0 are zero sets `halted` on the next clock edge. At the same edge `exit_code` takes the value of `reg2_lo` and `status` stays 0x00.
- R2: Fetches and loads to 0x10000000–0x10FFFFFF return the instruction RAM word in the same cycle. A store (kind 2) there sets `status` to 0xF5 on the next edge.
- R3: The data region 0x20000000–0x23FFFFFF reads as zero after reset and accepts loads and stores. A store writes only the enabled lanes. Byte offset k within a word is lane `req_be[3-k]` and occupies data bits 31-8k down to 24-8k.
- R4: A fetch outside the zero word and the instruction region faults (0xF5). A load from the zero word or from an unmapped address also faults (0xF5).
- R5: A full-word load (be 1111) from 0x30000000 returns {24'b0, `cin_byte`} and pulses `cin_take` when `cin_valid` is high. With `cin_valid` low and `cin_eos` high it returns 0xFFFFFFFF. With both low it holds `rsp_stall` high and does not take a byte. A store to this address faults.
- R6: A full-word store to 0x30000004 drives `cout_valid` with `cout_byte` = `req_wdata[7:0]` and stalls while `cout_ready` is low. `cout_err` sets `status` to 0xEB on the next edge. A load from this address faults.
- R7: Alignment rules:
  - A fetch with address bits 1:0 non-zero faults.
  - A load or store faults unless its enables are one of: 1111 at offset 0, 1100 at offset 0, 0011 at offset 2, or the single lane that matches the offset.
  - A console access with enables other than 1111 faults.
- R8: After a halt or fault, `status`, `halted` and `exit_code` hold until reset. Later requests give `rsp_rdata` = 0, `rsp_stall` = 0, no `cin_take` and no `cout_valid`.
- R9: `rsp_stall` is high only while a console read or write waits. RAM accesses never stall.
- R10: Status codes on `status` are 8-bit two's complement: 0x00 running, 0xF5 memory fault (-11), 0xEB I/O error (-21). `rsp_rdata` is 0 when no read is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_we | input | 1 | Write strobe for loading the instruction RAM |
| boot_idx | input | IW | Word index for the instruction RAM load |
| boot_word | input | 32 | Word to load |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Lane enables, bit 3 = bits 31:24 |
| req_wdata | input | 32 | Store data |
| reg2_lo | input | 8 | Low byte of core register 2 |
| rsp_rdata | output | 32 | Read data |
| rsp_stall | output | 1 | Core must hold the request |
| status | output | 8 | Latched status code |
| halted | output | 1 | Program finished |
| exit_code | output | 8 | Exit value captured at halt |
| cin_valid | input | 1 | Input byte available |
| cin_eos | input | 1 | Input stream ended |
| cin_byte | input | 8 | Input byte |
| cin_take | output | 1 | Input byte consumed |
| cout_valid | output | 1 | Output byte offered |
| cout_byte | output | 8 | Output byte |
| cout_ready | input | 1 | Output side accepts the byte |
| cout_err | input | 1 | Output side failed |

## Verification
The hardest situation to reach from the ports is a console access that waits through one or more cycles and is then completed or failed, because the result depends on how the stream inputs change under a held request. The stimulus holds a single request for several cycles and changes `cin_valid`, `cin_eos`, `cout_ready` and `cout_err` between samples. It checks stall, data and take/offer strobes at each step. The sticky behaviour is reached by first forcing a fault or halt and then replaying accesses that would otherwise write, read or stall.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_LOAD  = 2'd1;
  localparam logic [1:0] K_STORE = 2'd2;

  localparam logic [7:0]  INSTR_HI = 8'h10;
  localparam logic [5:0]  DATA_HI  = 6'b001000;
  localparam logic [31:0] CIN_ADDR  = 32'h3000_0000;
  localparam logic [31:0] COUT_ADDR = 32'h3000_0004;

  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_ARITH    = 8'hF6;
  localparam logic [7:0] ST_MEM      = 8'hF5;
  localparam logic [7:0] ST_INSN     = 8'hF4;
  localparam logic [7:0] ST_INTERNAL = 8'hEC;
  localparam logic [7:0] ST_IO       = 8'hEB;

  typedef enum logic [2:0] {
    A_NONE, A_HALT, A_IRD, A_DRD, A_DWR, A_CIN, A_COUT, A_FAULT
  } act_e;

  typedef enum logic [1:0] {S_RUN, S_HALT, S_FAULT} run_e;
endpackage

// File: rtl/mg_decode.sv
module mg_decode
  import mg_pkg::*;
(
  input  logic        valid,
  input  logic [1:0]  kind,
  input  logic [31:0] addr,
  input  logic [3:0]  be,
  output act_e        act
);
  logic in_zero, in_instr, in_data, at_cin, at_cout, lanes_ok, full;

  assign in_zero  = (addr[31:2] == 30'd0);
  assign in_instr = (addr[31:24] == INSTR_HI);
  assign in_data  = (addr[31:26] == DATA_HI);
  assign at_cin   = (addr == CIN_ADDR);
  assign at_cout  = (addr == COUT_ADDR);
  assign full     = (be == 4'b1111);

  always_comb begin
    case (addr[1:0])
      2'd0:    lanes_ok = (be == 4'b1111) || (be == 4'b1100) || (be == 4'b1000);
      2'd1:    lanes_ok = (be == 4'b0100);
      2'd2:    lanes_ok = (be == 4'b0011) || (be == 4'b0010);
      default: lanes_ok = (be == 4'b0001);
    endcase
  end

  always_comb begin
    act = A_NONE;
    if (valid) begin
      case (kind)
        K_FETCH: begin
          if (addr[1:0] != 2'd0) act = A_FAULT;
          else if (in_zero)      act = A_HALT;
          else if (in_instr)     act = A_IRD;
          else                   act = A_FAULT;
        end
        K_LOAD: begin
          if (!lanes_ok)            act = A_FAULT;
          else if (in_instr)        act = A_IRD;
          else if (in_data)         act = A_DRD;
          else if (at_cin && full)  act = A_CIN;
          else                      act = A_FAULT;
        end
        K_STORE: begin
          if (!lanes_ok)            act = A_FAULT;
          else if (in_data)         act = A_DWR;
          else if (at_cout && full) act = A_COUT;
          else                      act = A_FAULT;
        end
        default: act = A_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/mg_ram.sv
module mg_ram #(
  parameter int WORDS = 64,
  parameter bit CLEAR = 1'b1,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [3:0]    wbe,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  assign rdata = mem[ridx];

  generate
    if (CLEAR) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < WORDS; i++) mem[i] <= 32'd0;
        end else if (we) begin
          for (int b = 0; b < 4; b++)
            if (wbe[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end else begin : g_raw
      always_ff @(posedge clk) begin
        if (we) begin
          for (int b = 0; b < 4; b++)
            if (wbe[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mg_console.sv
module mg_console (
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic        cin_valid,
  input  logic        cin_eos,
  input  logic [7:0]  cin_byte,
  input  logic        cout_ready,
  input  logic        cout_err,
  input  logic [7:0]  wbyte,
  output logic [31:0] rd_word,
  output logic        cin_take,
  output logic        cout_valid,
  output logic [7:0]  cout_byte,
  output logic        hold,
  output logic        io_err
);
  always_comb begin
    if (cin_valid)    rd_word = {24'd0, cin_byte};
    else if (cin_eos) rd_word = 32'hFFFF_FFFF;
    else              rd_word = 32'd0;
  end

  assign cin_take   = rd_req & cin_valid;
  assign cout_valid = wr_req;
  assign cout_byte  = wr_req ? wbyte : 8'd0;
  assign io_err     = wr_req & cout_err;
  assign hold       = (rd_req & ~cin_valid & ~cin_eos) |
                      (wr_req & ~cout_ready & ~cout_err);
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int IWORDS = 64,
  parameter int DWORDS = 64,
  localparam int IW = $clog2(IWORDS),
  localparam int DW = $clog2(DWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_we,
  input  logic [IW-1:0] boot_idx,
  input  logic [31:0]   boot_word,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [31:0]   req_addr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  input  logic [7:0]    reg2_lo,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_stall,
  output logic [7:0]    status,
  output logic          halted,
  output logic [7:0]    exit_code,
  input  logic          cin_valid,
  input  logic          cin_eos,
  input  logic [7:0]    cin_byte,
  output logic          cin_take,
  output logic          cout_valid,
  output logic [7:0]    cout_byte,
  input  logic          cout_ready,
  input  logic          cout_err
);
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  run_e       state_q, state_d;
  logic [7:0] status_q, status_d;
  logic [7:0] exit_q;
  logic       exit_en;
  logic       run;
  act_e       act;
  logic [31:0] iram_q, dram_q, con_word;
  logic        dram_we, con_rd, con_wr, con_hold, con_err;

  assign run = (state_q == S_RUN);

  mg_decode u_dec (
    .valid(req_valid & run), .kind(req_kind), .addr(req_addr),
    .be(req_be), .act(act)
  );

  mg_ram #(.WORDS(IWORDS), .CLEAR(1'b0)) u_iram (
    .clk(clk), .rst_n(rst_ni), .we(boot_we), .widx(boot_idx),
    .wbe(4'b1111), .wdata(boot_word), .ridx(req_addr[IW+1:2]), .rdata(iram_q)
  );

  assign dram_we = (act == A_DWR);

  mg_ram #(.WORDS(DWORDS), .CLEAR(1'b1)) u_dram (
    .clk(clk), .rst_n(rst_ni), .we(dram_we), .widx(req_addr[DW+1:2]),
    .wbe(req_be), .wdata(req_wdata), .ridx(req_addr[DW+1:2]), .rdata(dram_q)
  );

  assign con_rd = (act == A_CIN);
  assign con_wr = (act == A_COUT);

  mg_console u_con (
    .rd_req(con_rd), .wr_req(con_wr), .cin_valid(cin_valid), .cin_eos(cin_eos),
    .cin_byte(cin_byte), .cout_ready(cout_ready), .cout_err(cout_err),
    .wbyte(req_wdata[7:0]), .rd_word(con_word), .cin_take(cin_take),
    .cout_valid(cout_valid), .cout_byte(cout_byte), .hold(con_hold),
    .io_err(con_err)
  );

  always_comb begin
    case (act)
      A_IRD:   rsp_rdata = iram_q;
      A_DRD:   rsp_rdata = dram_q;
      A_CIN:   rsp_rdata = con_word;
      default: rsp_rdata = 32'd0;
    endcase
  end
  assign rsp_stall = con_hold;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    exit_en  = 1'b0;
    if (act == A_HALT) begin
      state_d = S_HALT;
      exit_en = 1'b1;
    end else if (act == A_FAULT) begin
      state_d  = S_FAULT;
      status_d = ST_MEM;
    end else if (con_err) begin
      state_d  = S_FAULT;
      status_d = ST_IO;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_RUN;
      status_q <= ST_OK;
    end else if (run) begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      exit_q <= 8'd0;
    else if (exit_en) exit_q <= reg2_lo;
  end

  assign status    = status_q;
  assign halted    = (state_q == S_HALT);
  assign exit_code = exit_q;

  // R9
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_stall |-> (req_valid && (req_addr == CIN_ADDR || req_addr == COUT_ADDR)));

  // R8
  sticky_code_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != S_RUN) |=> ($stable(status_q) && $stable(state_q) && $stable(exit_q)));

  // R3
  data_wr_region_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    dram_we |-> (req_addr[31:26] == DATA_HI && req_kind == K_STORE && run));

  // R5
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cin_take |-> (cin_valid && req_addr == CIN_ADDR && req_kind == K_LOAD));

  // R1
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(halted) |-> ($past(req_addr) == 32'd0 && $past(req_kind) == K_FETCH
                       && status_q == ST_OK));

  // R6
  io_code_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && cout_valid && cout_err) |=> (status_q == ST_IO));
endmodule

// File: tb/sim_mem_guard.sv
module sim_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_we;
  logic [5:0]  boot_idx;
  logic [31:0] boot_word;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [7:0]  reg2_lo;
  logic [31:0] rsp_rdata;
  logic        rsp_stall;
  logic [7:0]  status;
  logic        halted;
  logic [7:0]  exit_code;
  logic        cin_valid, cin_eos, cin_take;
  logic [7:0]  cin_byte;
  logic        cout_valid, cout_ready, cout_err;
  logic [7:0]  cout_byte;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mem_guard u0 (
    .clk(clk), .rst_n(rst_n), .boot_we(boot_we), .boot_idx(boot_idx),
    .boot_word(boot_word), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .reg2_lo(reg2_lo), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .status(status), .halted(halted), .exit_code(exit_code),
    .cin_valid(cin_valid), .cin_eos(cin_eos), .cin_byte(cin_byte),
    .cin_take(cin_take), .cout_valid(cout_valid), .cout_byte(cout_byte),
    .cout_ready(cout_ready), .cout_err(cout_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = 32'd0;
    req_be = 4'd0; req_wdata = 32'd0; reg2_lo = 8'd0; boot_we = 1'b0;
    boot_idx = '0; boot_word = 32'd0; cin_valid = 1'b0; cin_eos = 1'b0;
    cin_byte = 8'd0; cout_ready = 1'b0; cout_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive a request at a falling edge, leave time for combinational outputs
  task automatic go(input logic [1:0] k, input logic [31:0] a,
                    input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_be = be; req_wdata = wd;
    #5;
  endtask

  // let the request pass one rising edge, then drop it
  task automatic fin();
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 status after reset", {24'd0, status}, 32'h00);
    chk("R1 halted after reset", {31'd0, halted}, 32'd0);
    chk("R9 stall idle", {31'd0, rsp_stall}, 32'd0);
    chk("R10 rdata idle", rsp_rdata, 32'd0);
    go(2'd1, 32'h2000_0010, 4'b1111, 32'd0);
    chk("R3 data zero after reset", rsp_rdata, 32'd0);
    fin();
  endtask

  task automatic t_data_lanes();
    do_reset();
    go(2'd2, 32'h2000_0000, 4'b1111, 32'h1122_3344);
    chk("R9 no stall on ram store", {31'd0, rsp_stall}, 32'd0);
    fin();
    go(2'd2, 32'h2000_0001, 4'b0100, 32'h00AA_0000); fin();
    go(2'd2, 32'h2000_0002, 4'b0011, 32'h0000_BEEF); fin();
    go(2'd1, 32'h2000_0000, 4'b1111, 32'd0);
    chk("R3 big-endian lanes", rsp_rdata, 32'h11AA_BEEF);
    fin();
    go(2'd1, 32'h2000_0003, 4'b0001, 32'd0);
    chk("R3 byte load word data", rsp_rdata, 32'h11AA_BEEF);
    fin();
    chk("R10 status ok after ram", {24'd0, status}, 32'h00);
  endtask

  task automatic t_instr();
    do_reset();
    @(negedge clk);
    boot_we = 1'b1; boot_idx = 6'd3; boot_word = 32'hCAFE_F00D;
    @(negedge clk);
    boot_we = 1'b0;
    go(2'd0, 32'h1000_000C, 4'b1111, 32'd0);
    chk("R2 fetch instr word", rsp_rdata, 32'hCAFE_F00D);
    fin();
    go(2'd1, 32'h1000_000C, 4'b1111, 32'd0);
    chk("R2 load instr word", rsp_rdata, 32'hCAFE_F00D);
    fin();
    go(2'd2, 32'h1000_0000, 4'b1111, 32'h1);
    fin();
    chk("R2 store to instr faults", {24'd0, status}, 32'hF5);
  endtask

  task automatic t_halt();
    do_reset();
    reg2_lo = 8'hAB;
    go(2'd0, 32'h0000_0000, 4'b1111, 32'd0);
    fin();
    reg2_lo = 8'h11;
    chk("R1 halted", {31'd0, halted}, 32'd1);
    chk("R1 exit code", {24'd0, exit_code}, 32'hAB);
    chk("R1 status stays ok", {24'd0, status}, 32'h00);
    go(2'd2, 32'h3000_0004, 4'b1111, 32'h41);
    chk("R8 no output after halt", {31'd0, cout_valid}, 32'd0);
    chk("R8 no stall after halt", {31'd0, rsp_stall}, 32'd0);
    fin();
    go(2'd1, 32'h0000_0000, 4'b1111, 32'd0);
    fin();
    chk("R8 status held after halt", {24'd0, status}, 32'h00);
    chk("R8 exit held", {24'd0, exit_code}, 32'hAB);
  endtask

  task automatic t_region_faults();
    do_reset();
    go(2'd0, 32'h2000_0000, 4'b1111, 32'd0); fin();
    chk("R4 fetch from data faults", {24'd0, status}, 32'hF5);
    cin_valid = 1'b1; cin_byte = 8'h33;
    go(2'd1, 32'h3000_0000, 4'b1111, 32'd0);
    chk("R8 no take after fault", {31'd0, cin_take}, 32'd0);
    chk("R8 rdata zero after fault", rsp_rdata, 32'd0);
    fin();
    do_reset();
    go(2'd1, 32'h4000_0000, 4'b1111, 32'd0); fin();
    chk("R4 unmapped load faults", {24'd0, status}, 32'hF5);
    do_reset();
    go(2'd1, 32'h0000_0000, 4'b1111, 32'd0); fin();
    chk("R4 load of zero word faults", {24'd0, status}, 32'hF5);
    chk("R4 load of zero word no halt", {31'd0, halted}, 32'd0);
  endtask

  task automatic t_align();
    do_reset();
    go(2'd0, 32'h1000_0002, 4'b1111, 32'd0); fin();
    chk("R7 misaligned fetch", {24'd0, status}, 32'hF5);
    do_reset();
    go(2'd2, 32'h2000_0002, 4'b1111, 32'd0); fin();
    chk("R7 misaligned word store", {24'd0, status}, 32'hF5);
    do_reset();
    go(2'd2, 32'h2000_0001, 4'b1000, 32'd0); fin();
    chk("R7 lane mismatch", {24'd0, status}, 32'hF5);
    do_reset();
    go(2'd1, 32'h3000_0000, 4'b1100, 32'd0); fin();
    chk("R7 half console load", {24'd0, status}, 32'hF5);
  endtask

  task automatic t_cin();
    do_reset();
    go(2'd1, 32'h3000_0000, 4'b1111, 32'd0);
    chk("R5 stall waiting input", {31'd0, rsp_stall}, 32'd1);
    chk("R5 no take while waiting", {31'd0, cin_take}, 32'd0);
    @(negedge clk);
    cin_valid = 1'b1; cin_byte = 8'hC1; #5;
    chk("R5 byte zero-extended", rsp_rdata, 32'h0000_00C1);
    chk("R5 take strobe", {31'd0, cin_take}, 32'd1);
    chk("R9 stall released", {31'd0, rsp_stall}, 32'd0);
    @(negedge clk);
    cin_valid = 1'b0; cin_eos = 1'b1; #5;
    chk("R5 end of stream", rsp_rdata, 32'hFFFF_FFFF);
    chk("R5 no stall at end", {31'd0, rsp_stall}, 32'd0);
    fin();
    chk("R10 status after input", {24'd0, status}, 32'h00);
    go(2'd2, 32'h3000_0000, 4'b1111, 32'd0); fin();
    chk("R5 store to input faults", {24'd0, status}, 32'hF5);
  endtask

  task automatic t_cout();
    do_reset();
    go(2'd2, 32'h3000_0004, 4'b1111, 32'h1234_565A);
    chk("R6 offer byte", {24'd0, cout_byte}, 32'h5A);
    chk("R6 offer valid", {31'd0, cout_valid}, 32'd1);
    chk("R6 stall not ready", {31'd0, rsp_stall}, 32'd1);
    @(negedge clk);
    cout_ready = 1'b1; #5;
    chk("R6 done when ready", {31'd0, rsp_stall}, 32'd0);
    fin();
    chk("R6 status ok", {24'd0, status}, 32'h00);
    cout_ready = 1'b0; cout_err = 1'b1;
    go(2'd2, 32'h3000_0004, 4'b1111, 32'h41); fin();
    chk("R6 io error code", {24'd0, status}, 32'hEB);
    do_reset();
    go(2'd1, 32'h3000_0004, 4'b1111, 32'd0); fin();
    chk("R6 load from output faults", {24'd0, status}, 32'hF5);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_data_lanes();
    t_instr();
    t_halt();
    t_region_faults();
    t_align();
    t_cin();
    t_cout();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule